// File: doc/BRIEF.md
# Hybrid Ternary Line Encoder

This block turns a serial stream of binary data into a stream of three-level line symbols. It emits one symbol for each accepted bit, so the symbol rate equals the bit rate. Each new symbol depends on two things: the incoming bit and the level that was sent last. A bit of 1 drives the line towards the positive level. A bit of 0 drives it towards the negative level. When the line already sits at the level that the bit asks for, the encoder returns it to zero instead.

The effect on the line depends on the data pattern:
- Alternating data gives alternating positive and negative symbols.
- A run of ones gives positive, zero, positive, zero and so on.
- A run of zeros gives negative, zero, negative, zero and so on.

An upstream source presents a bit together with a strobe. One clock later the encoder shows the new level on a two-wire code with a valid flag. A later analog stage turns the code into line voltages. The single register of state is the last level sent. Reset sets that register to zero.

Top module: `hter_line_enc`

## Requirements
- R1: The level code is two bits: positive = 2'b10, zero = 2'b00, negative = 2'b01.
- R2: An accepted bit of 1 when the current level is zero or negative makes the next level positive.
- R3: An accepted bit of 1 when the current level is positive makes the next level zero.
- R4: An accepted bit of 0 when the current level is zero or positive makes the next level negative.
- R5: An accepted bit of 0 when the current level is negative makes the next level zero.
- R6: Starting from zero, the data 1010... gives +,-,+,-; a run of ones gives +,0,+,0; a run of zeros gives -,0,-,0.
- R7: Each bit accepted with `bit_vld` high gives exactly one symbol. `sym_vld` is high on the cycle after the bit was accepted and low on the cycle after any cycle where `bit_vld` was low.
- R8: While reset is held, and after reset until the first accepted bit, `sym_out` is 2'b00 and `sym_vld` is 0.
- R9: On a cycle where `bit_vld` is low, the value on `din` has no effect, and `sym_out` keeps its value on the next cycle.
- R10: The code 2'b11 never appears on `sym_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the stored level to zero |
| bit_vld | input | 1 | High on cycles that carry a data bit |
| din | input | 1 | Data bit; used only when `bit_vld` is high |
| sym_out | output | 2 | Current line level code (10 positive, 00 zero, 01 negative) |
| sym_vld | output | 1 | High for one cycle after each accepted bit |

## Verification
The properties assume that `bit_vld` and `din` are synchronous to `clk` and never unknown while reset is released. They also assume that `rst_n` is the only way the stored level changes outside an accepted bit. The bench drives every input on the falling clock edge. This keeps inputs settled well before the rising edge at which the encoder samples them. The stimulus leaves `din` toggling freely on idle cycles, so the hold rule is tested against real activity. Reset is asserted again during the run so that each pattern starts from the zero level.

// File: rtl/hter_pkg.sv
package hter_pkg;

   localparam int SYM_W = 2;

   // Two-wire level code: bit 1 marks positive, bit 0 marks negative (R1)
   typedef enum logic [SYM_W-1:0] {
      LVL_ZERO = 2'b00,
      LVL_NEG  = 2'b01,
      LVL_POS  = 2'b10
   } lvl_e;

   // State-table form of the transition rule
   function automatic lvl_e step_table(input lvl_e prev, input logic bit_i);
      lvl_e res;
      unique case ({bit_i, prev})
         {1'b1, LVL_ZERO}: res = LVL_POS;   // R2
         {1'b1, LVL_NEG}:  res = LVL_POS;   // R2
         {1'b1, LVL_POS}:  res = LVL_ZERO;  // R3
         {1'b0, LVL_ZERO}: res = LVL_NEG;   // R4
         {1'b0, LVL_POS}:  res = LVL_NEG;   // R4
         {1'b0, LVL_NEG}:  res = LVL_ZERO;  // R5
         default:          res = LVL_ZERO;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/hter_next_sym.sv
module hter_next_sym
   import hter_pkg::*;
#(
   parameter string IMPL = "LOGIC"
) (
   input  lvl_e prev_lvl,
   input  logic bit_i,
   output lvl_e next_lvl
);

   generate
      if (IMPL == "TABLE") begin : g_table
         always_comb next_lvl = step_table(prev_lvl, bit_i);
      end else if (IMPL == "LOGIC") begin : g_logic
         // A one sets the positive wire unless it is already set; a zero
         // does the same for the negative wire. Both wires can never be set.
         logic pos_w;
         logic neg_w;
         assign pos_w = prev_lvl[1];
         assign neg_w = prev_lvl[0];
         always_comb next_lvl = lvl_e'({bit_i & ~pos_w, ~bit_i & ~neg_w});
      end else begin : g_bad_impl
         $error("hter_next_sym: IMPL must be TABLE or LOGIC");
      end
   endgenerate

endmodule

// File: rtl/hter_lvl_reg.sv
module hter_lvl_reg
   import hter_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  lvl_e next_lvl,
   output lvl_e cur_lvl,
   output logic load_d
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lvl <= LVL_ZERO;
         load_d  <= 1'b0;
      end else begin
         load_d <= load;
         if (load) cur_lvl <= next_lvl;
      end
   end

endmodule

// File: rtl/hter_line_enc.sv
module hter_line_enc
   import hter_pkg::*;
#(
   parameter string IMPL = "LOGIC"
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             din,
   output logic [SYM_W-1:0] sym_out,
   output logic             sym_vld
);

   lvl_e lvl_q;
   lvl_e lvl_d;

   generate
      if (SYM_W != 2) begin : g_bad_width
         $error("hter_line_enc: level code must be two bits");
      end
   endgenerate

   hter_next_sym #(.IMPL(IMPL)) u_next (
      .prev_lvl (lvl_q),
      .bit_i    (din),
      .next_lvl (lvl_d)
   );

   hter_lvl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bit_vld),
      .next_lvl (lvl_d),
      .cur_lvl  (lvl_q),
      .load_d   (sym_vld)
   );

   assign sym_out = lvl_q;

endmodule

// File: rtl/hter_line_enc_chk.sv
module hter_line_enc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_vld,
   input logic       din,
   input logic [1:0] sym_out,
   input logic       sym_vld
);

   p_set_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && din && sym_out != 2'b10) |=> sym_out == 2'b10);

   p_clr_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && din && sym_out == 2'b10) |=> sym_out == 2'b00);

   p_set_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !din && sym_out != 2'b01) |=> sym_out == 2'b01);

   p_clr_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !din && sym_out == 2'b01) |=> sym_out == 2'b00);

   p_vld_after_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |=> sym_vld);

   p_no_vld_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> !sym_vld);

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(sym_out));

   p_no_code11_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sym_out != 2'b11);

endmodule

bind hter_line_enc hter_line_enc_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_vld (bit_vld),
   .din     (din),
   .sym_out (sym_out),
   .sym_vld (sym_vld)
);

// File: tb/hter_line_enc_bench.sv
module hter_line_enc_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       din = 1'b0;
   logic [1:0] sym_out;
   logic       sym_vld;

   int total = 0;
   int bad   = 0;
   int lvl   = 0;     // reference level: +1, 0, -1
   bit seen  = 1'b0;  // a bit accepted since the last reset
   bit done  = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   hter_line_enc u_hter_line_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .din     (din),
      .sym_out (sym_out),
      .sym_vld (sym_vld)
   );

   // R1 code mapping
   function automatic logic [1:0] enc(input int l);
      if (l > 0) return 2'b10;
      if (l < 0) return 2'b01;
      return 2'b00;
   endfunction

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic v, input logic d);
      string tag;
      bit_vld = v;
      din     = d;
      if (!v)      tag = seen ? "R9" : "R8";
      else if (d)  tag = (lvl == 1)  ? "R3" : "R2";
      else         tag = (lvl == -1) ? "R5" : "R4";
      if (v) begin
         if (d) lvl = (lvl == 1)  ? 0 : 1;
         else   lvl = (lvl == -1) ? 0 : -1;
         seen = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, sym_out, enc(lvl));
      chk("R7", {1'b0, sym_vld}, {1'b0, v});
      chk("R10", {1'b0, sym_out == 2'b11}, 2'b00);
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      bit_vld = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R8", sym_out, 2'b00);
      chk("R8", {1'b0, sym_vld}, 2'b00);
      rst_n = 1'b1;
      lvl   = 0;
      seen  = 1'b0;
   endtask

   task automatic pattern(input logic [7:0] bits, input logic [15:0] exp);
      do_reset();
      for (int i = 0; i < 8; i++) begin
         step(1'b1, bits[7-i]);
         chk("R6", sym_out, exp[15-2*i -: 2]);
      end
   endtask

   initial begin
      logic [15:0] lfsr;
      @(negedge clk);
      do_reset();
      // R8: idle after reset, din toggling, output stays zero
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);

      // R1 explicit codes
      step(1'b1, 1'b1); chk("R1", sym_out, 2'b10);
      step(1'b1, 1'b1); chk("R1", sym_out, 2'b00);
      step(1'b1, 1'b0); chk("R1", sym_out, 2'b01);

      // R9: idle with toggling din holds negative level
      step(1'b0, 1'b1); chk("R9", sym_out, 2'b01);
      step(1'b0, 1'b0); chk("R9", sym_out, 2'b01);
      step(1'b1, 1'b1); // R2 from negative
      step(1'b0, 1'b0); chk("R9", sym_out, 2'b10);
      step(1'b1, 1'b0); // R4 from positive
      step(1'b1, 1'b0); // R5

      // R6 patterns from the zero level
      pattern(8'b1010_1010, 16'h9999);
      pattern(8'b1111_1111, 16'h8888);
      pattern(8'b0000_0000, 16'h4444);

      // Mixed data with gaps, reset asserted mid-run
      do_reset();
      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[3:2] != 2'b00, lfsr[7]);
         if (n == 300) do_reset();
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule